// File: doc/BRIEF.md
# Multi-width compare flag unit

This block compares two integers by subtracting the second from the first and reports only the resulting status flags. The difference itself never leaves the block. A datapath uses it wherever a compare sets the flags for a later conditional branch, move or set. The flags are carry, zero, sign, overflow, auxiliary carry and parity. They are derived exactly as a subtract of the same operands would derive them, at a width chosen per operation.

The second operand comes either from a full-width input or from an immediate field. An immediate is sign-extended to the selected operand length before the subtract. A short-immediate indicator lets an 8-bit immediate stand in for wider operands. The unit is purely combinational. It holds no state, so there are no states or transitions: every output follows the inputs after the logic settles.

Top module: `cmpf_unit`

## Requirements
- R1: The flags reflect first operand minus second operand at the selected width; equal operands give zero set and carry clear, and no difference value is output.
- R2: `size_sel` picks the width: 0 gives 8 bits, 1 gives 16, 2 gives 32, 3 gives 64.
- R3: `flag_c` is set exactly when the first operand, taken as unsigned at the selected width, is less than the second (a borrow out of the top bit).
- R4: `flag_z` is set exactly when the difference is zero in all bits of the selected width.
- R5: `flag_s` equals the top bit of the difference at the selected width.
- R6: `flag_o` is set when the operands differ in sign and the sign of the difference differs from the sign of the first operand.
- R7: `flag_a` is set when a borrow leaves bit 3, that is, when the low four bits of the first operand are less than those of the second.
- R8: `flag_p` is set when the low 8 bits of the difference hold an even number of ones.
- R9: With `use_imm` high, `opb` is ignored and the second operand is `imm` sign-extended. It uses `imm[7:0]` at 8 bits, `imm[15:0]` at 16 bits, and `imm[31:0]` at 32 and 64 bits.
- R10: With `imm_byte` high and `use_imm` high, `imm[7:0]` is sign-extended to the selected width at every width.
- R11: Input bits above the selected width, and immediate bits above the immediate length, have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | First operand (minuend) |
| opb | input | 64 | Second operand when no immediate is used |
| imm | input | 32 | Immediate field |
| use_imm | input | 1 | Take the second operand from `imm` |
| imm_byte | input | 1 | Immediate is 8 bits long |
| size_sel | input | 2 | Operand width select |
| flag_c | output | 1 | Carry (unsigned borrow) |
| flag_z | output | 1 | Zero |
| flag_s | output | 1 | Sign |
| flag_o | output | 1 | Signed overflow |
| flag_a | output | 1 | Auxiliary carry (borrow from bit 3) |
| flag_p | output | 1 | Even parity of low result byte |

## Verification
The assertions assume that every input is a known value that has settled before it is evaluated. Combinations of flags are therefore judged only when the operands and selects are stable together. The bench changes all inputs at once, a full clock period apart, and drives only fully specified values with no X or Z. It reads the flags at the opposite clock edge. Operand values are taken from a hand-worked table, from directed corner cases, and from a shift-register sequence whose expected flags come from a model that aligns the operands at the top bit.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

    localparam int MAX_W     = 64;
    localparam int IMM_W     = 32;
    localparam int NUM_SIZES = 4;
    localparam int SEL_W     = $clog2(NUM_SIZES);

    typedef enum logic [SEL_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } opsize_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic af;
        logic pf;
    } flags_t;

endpackage

// File: rtl/cmpf_imm_ext.sv
// Sign-extends the immediate field to the full datapath width (R9, R10).
module cmpf_imm_ext
    import cmpf_pkg::*;
#(
    parameter int DW = MAX_W,
    parameter int IW = IMM_W
) (
    input  logic [IW-1:0] imm,
    input  logic          imm_byte,
    input  opsize_e       size,
    output logic [DW-1:0] imm_ext
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [DW-1:0] ext_byte;
    logic [DW-1:0] ext_half;
    logic [DW-1:0] ext_full;

    always_comb begin
        ext_byte = {{(DW-BYTE_W){imm[BYTE_W-1]}}, imm[BYTE_W-1:0]};
        ext_half = {{(DW-HALF_W){imm[HALF_W-1]}}, imm[HALF_W-1:0]};
        ext_full = {{(DW-IW){imm[IW-1]}}, imm};
    end

    always_comb begin
        unique case (size)
            SZ_BYTE:  imm_ext = ext_byte;
            SZ_WORD:  imm_ext = imm_byte ? ext_byte : ext_half;
            SZ_DWORD: imm_ext = imm_byte ? ext_byte : ext_full;
            SZ_QWORD: imm_ext = imm_byte ? ext_byte : ext_full;
            default:  imm_ext = ext_full;
        endcase
    end

endmodule

// File: rtl/cmpf_lane_sub.sv
// One fixed-width subtract lane producing the full flag set (R3-R8).
module cmpf_lane_sub
    import cmpf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output flags_t       fl
);

    localparam int NIB = 4;
    localparam int PB  = 8;

    logic [W:0]   wide;
    logic [W-1:0] diff;
    logic [W-1:0] half_sum;

    always_comb begin
        wide     = {1'b0, a} - {1'b0, b};
        diff     = wide[W-1:0];
        half_sum = a ^ b ^ diff;
        fl.cf    = wide[W];
        fl.zf    = (diff == '0);
        fl.sf    = diff[W-1];
        fl.of    = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
        fl.af    = half_sum[NIB];
        fl.pf    = ~(^diff[PB-1:0]);
    end

endmodule

// File: rtl/cmpf_unit.sv
// Multi-width compare: flags only, difference discarded (R1, R2, R11).
module cmpf_unit
    import cmpf_pkg::*;
(
    input  logic [63:0] opa,
    input  logic [63:0] opb,
    input  logic [31:0] imm,
    input  logic        use_imm,
    input  logic        imm_byte,
    input  logic [1:0]  size_sel,
    output logic        flag_c,
    output logic        flag_z,
    output logic        flag_s,
    output logic        flag_o,
    output logic        flag_a,
    output logic        flag_p
);

    opsize_e       size;
    logic [MAX_W-1:0] imm_ext;
    logic [MAX_W-1:0] second;
    flags_t        lane_fl [NUM_SIZES];
    flags_t        sel_fl;

    assign size = opsize_e'(size_sel);

    cmpf_imm_ext #(
        .DW (MAX_W),
        .IW (IMM_W)
    ) u_imm (
        .imm      (imm),
        .imm_byte (imm_byte),
        .size     (size),
        .imm_ext  (imm_ext)
    );

    always_comb begin
        second = use_imm ? imm_ext : opb;
    end

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = 8 << g;
        cmpf_lane_sub #(.W(LW)) u_lane (
            .a  (opa[LW-1:0]),
            .b  (second[LW-1:0]),
            .fl (lane_fl[g])
        );
    end

    always_comb begin
        unique case (size)
            SZ_BYTE:  sel_fl = lane_fl[0];
            SZ_WORD:  sel_fl = lane_fl[1];
            SZ_DWORD: sel_fl = lane_fl[2];
            SZ_QWORD: sel_fl = lane_fl[3];
            default:  sel_fl = lane_fl[3];
        endcase
    end

    assign flag_c = sel_fl.cf;
    assign flag_z = sel_fl.zf;
    assign flag_s = sel_fl.sf;
    assign flag_o = sel_fl.of;
    assign flag_a = sel_fl.af;
    assign flag_p = sel_fl.pf;

endmodule

// File: rtl/cmpf_unit_chk.sv
// Flag consistency checks, attached to the top by bind.
module cmpf_unit_chk (
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        use_imm,
    input logic [1:0]  size_sel,
    input logic        flag_c,
    input logic        flag_z,
    input logic        flag_s,
    input logic        flag_o,
    input logic        flag_a,
    input logic        flag_p
);

    always_comb begin
        assert_known_sel_R2: assert (!$isunknown(size_sel));
        if (!use_imm && opa == opb) begin
            assert_equal_zero_R1: assert (flag_z && !flag_c);
        end
        if (flag_z) begin
            assert_zero_noborrow_R3: assert (!flag_c);
            assert_zero_clean_R4: assert (!flag_s && !flag_o);
            assert_zero_noaux_R7: assert (!flag_a);
            assert_zero_parity_R8: assert (flag_p);
        end
    end

endmodule

bind cmpf_unit cmpf_unit_chk u_chk (
    .opa      (opa),
    .opb      (opb),
    .use_imm  (use_imm),
    .size_sel (size_sel),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .flag_s   (flag_s),
    .flag_o   (flag_o),
    .flag_a   (flag_a),
    .flag_p   (flag_p)
);

// File: tb/cmpf_unit_test.sv
`timescale 1ns/1ps
module cmpf_unit_test;

    logic        clk = 1'b0;
    logic [63:0] opa;
    logic [63:0] opb;
    logic [31:0] imm;
    logic        use_imm;
    logic        imm_byte;
    logic [1:0]  size_sel;
    logic        flag_c, flag_z, flag_s, flag_o, flag_a, flag_p;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cmpf_unit uut (
        .opa      (opa),
        .opb      (opb),
        .imm      (imm),
        .use_imm  (use_imm),
        .imm_byte (imm_byte),
        .size_sel (size_sel),
        .flag_c   (flag_c),
        .flag_z   (flag_z),
        .flag_s   (flag_s),
        .flag_o   (flag_o),
        .flag_a   (flag_a),
        .flag_p   (flag_p)
    );

    // expected flags packed as {C,Z,S,O,A,P}
    typedef struct packed {
        logic [1:0]  sz;
        logic        ui;
        logic        ib;
        logic [63:0] a;
        logic [63:0] b;
        logic [31:0] im;
        logic [5:0]  ex;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 64'h05, 64'h05, 32'h0, 6'b010001},                    // R1 R4
        '{2'd0, 1'b0, 1'b0, 64'h00, 64'h01, 32'h0, 6'b101011},                    // R3 R7
        '{2'd0, 1'b0, 1'b0, 64'h80, 64'h01, 32'h0, 6'b000110},                    // R6
        '{2'd1, 1'b0, 1'b0, 64'h7FFF, 64'hFFFF, 32'h0, 6'b101101},                // R2 R5
        '{2'd2, 1'b0, 1'b0, 64'hDEADBEEF_12345678, 64'hFFFFFFFF_12345678, 32'h0, 6'b010001}, // R11
        '{2'd3, 1'b0, 1'b0, 64'h0, 64'h1, 32'h0, 6'b101011},                      // R2 R3
        '{2'd3, 1'b0, 1'b0, 64'h80000000_00000000, 64'h1, 32'h0, 6'b000111},      // R6
        '{2'd3, 1'b1, 1'b0, 64'h0, 64'h0, 32'hFFFFFFFF, 6'b100010},               // R9
        '{2'd2, 1'b1, 1'b1, 64'hFFFFFFFF, 64'h0, 32'h000000FF, 6'b010001},        // R10
        '{2'd1, 1'b1, 1'b0, 64'h0, 64'h0, 32'h12348000, 6'b101101},               // R9 R11
        '{2'd0, 1'b1, 1'b0, 64'h03, 64'h55, 32'h0000AB03, 6'b010001},             // R9 R11
        '{2'd0, 1'b0, 1'b0, 64'h10, 64'h01, 32'h0, 6'b000011}                     // R7 R8
    };
    string vreq [NV] = '{"R1", "R3", "R6", "R5", "R11", "R3",
                         "R6", "R9", "R10", "R9", "R11", "R8"};

    function automatic logic [5:0] model(input logic [1:0] sz, input logic ui,
                                         input logic ib, input logic [63:0] a,
                                         input logic [63:0] b, input logic [31:0] im);
        int w, iw;
        logic signed [63:0] t;
        logic [63:0] bv, at, bt, dt, lo;
        logic c, z, s, o, ax, p;
        w = 8 << sz;
        if (ui) begin
            iw = (sz == 2'd0 || ib) ? 8 : (sz == 2'd1 ? 16 : 32);
            t  = {im, 32'h0} << (32 - iw);
            bv = t >>> (64 - iw);
        end else begin
            bv = b;
        end
        at = a << (64 - w);
        bt = bv << (64 - w);
        dt = at - bt;
        c  = at < bt;
        z  = dt == 64'h0;
        s  = dt[63];
        o  = s ^ ($signed(at) < $signed(bt));
        ax = a[3:0] < bv[3:0];
        lo = a - bv;
        p  = ($countones(lo[7:0]) % 2) == 0;
        return {c, z, s, o, ax, p};
    endfunction

    task automatic apply(input logic [1:0] sz, input logic ui, input logic ib,
                         input logic [63:0] a, input logic [63:0] b, input logic [31:0] im);
        @(posedge clk);
        size_sel = sz; use_imm = ui; imm_byte = ib; opa = a; opb = b; imm = im;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {flag_c, flag_z, flag_s, flag_o, flag_a, flag_p};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: flags CZSOAP actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] x;
        logic [63:0] y;
        opa = '0; opb = '0; imm = '0; use_imm = 1'b0; imm_byte = 1'b0; size_sel = 2'd0;
        @(negedge clk);
        // idle inputs, all zero: R4 zero and R8 even parity
        check("R4", 6'b010001);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].sz, VECS[i].ui, VECS[i].ib, VECS[i].a, VECS[i].b, VECS[i].im);
            check(vreq[i], VECS[i].ex);
        end

        // R9: opb ignored with immediate, 16-bit, 5 - 7 = 0xFFFE
        apply(2'd1, 1'b1, 1'b0, 64'h5, 64'h5, 32'h7);
        check("R9", 6'b101010);
        // R10: byte immediate 0xFF is -1 at 64 bits
        apply(2'd3, 1'b1, 1'b1, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 32'hFF);
        check("R10", 6'b010001);
        // R10 contrast: full-length immediate 0xFF stays positive
        apply(2'd3, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 32'hFF);
        check("R10", 6'b001001);
        // R11: upper bits differ at byte width
        apply(2'd0, 1'b0, 1'b0, 64'hFFFF0000_00000005, 64'h12345678_9ABCDE05, 32'h0);
        check("R11", 6'b010001);

        // R2-R8 model sweep over all widths and operand sources
        x = 64'h9E3779B9_7F4A7C15;
        y = 64'hD1B54A32_D192ED03;
        for (int k = 0; k < 400; k++) begin
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            y = y ^ (y << 11); y = y ^ (y >> 9); y = y ^ (y << 23);
            if (k % 5 == 0) y = x ^ 64'h1;
            apply(x[1:0], y[0], y[1], x, y, y[63:32]);
            check("R6", model(x[1:0], y[0], y[1], x, y, y[63:32]));
        end

        finish_run();
    end

endmodule